// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between a processor and the message object store of a CAN-style controller. The processor stages one object's worth of fields in a set of buffer registers, picks a direction and a set of field groups in a command mask, and then writes a message number to launch a transfer. The engine then runs a read-modify-write on the chosen RAM entry. It moves only the groups the mask selects: the identifier mask, the arbitration fields, the control word, the low data word and the high data word. Groups that are not selected stay as they were at the destination.

In the read direction (object to buffer) the engine can also clear the stored interrupt-pending and new-data flags. The buffer still receives the flag values as they were before the clear. In the write direction (buffer to object) a single mask bit can raise the stored transmit request, whatever the buffer's control word holds. Every transfer takes the same fixed number of cycles. A busy flag marks the window in which the buffer and the command registers are locked.

Top module: `msgobj_xfer`

## Requirements
- R1: Writing register address 1 while idle starts a transfer for the message number in `cpu_wdata[7:0]`. Bit 15 of address 1 (busy) reads 1 from the next cycle. Bits 7:0 of address 1 read back the number that was written.
- R2: Busy stays 1 for exactly XFER_CYCLES (4) cycles. This holds for every mask value. The results are visible in the registers and the RAM once busy reads 0.
- R3: While busy is 1, a write to any register (0 to 6) is ignored. This includes a second start request.
- R4: Message numbers 1 to 32 select objects 1 to 32. Number 0 selects object 1. A number n above 32 selects object ((n-1) mod 32)+1.
- R5: The command mask sits at address 0. Bit 7 is the direction (1 = buffer to object). In the read direction (bit 7 = 0), bit 6 copies the stored identifier-mask word into address 2 and bit 5 copies the stored arbitration word into address 3. A clear bit leaves that buffer register as it was. Bit 29 of address 2 always reads 0.
- R6: In the read direction, mask bit 4 copies the stored 12-bit control word into address 4. Control bit 11 is new-data, bit 10 is interrupt-pending and bit 9 is transmit-request. Mask bit 3 clears the stored bit 10 and mask bit 2 clears the stored bit 11. The buffer receives the values from before the clear.
- R7: Mask bit 1 moves the low data word (address 5) and mask bit 0 moves the high data word (address 6). Each acts on its own word and works in both directions. An unselected word is left as it was at the destination.
- R8: In the write direction, mask bits 6, 5 and 4 copy addresses 2, 3 and 4 into the object. Unselected groups in the object stay as they were. The buffer registers do not change.
- R9: In the write direction, mask bit 3 has no effect.
- R10: In the write direction, mask bit 2 set to 1 forces the stored transmit-request (control bit 9) to 1, whatever the buffer's bit 9 holds. With mask bit 2 clear, that bit follows the buffer when mask bit 4 is set and is unchanged when mask bit 4 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps all 256 values of the command mask, which covers both directions and every combination of groups, flag clears and forced transmit request. Each transfer uses a fresh buffer pattern and a message number that steps through 0 to 39. After each transfer the bench compares the buffer registers against an arithmetic model. It then re-reads the whole target object and compares it too. These checks separate a group that was copied by mistake, a group that was wrongly held, a flag that was cleared in the wrong direction, a transmit request that was not forced, and a number that was mapped to the wrong object. The bench also measures the busy length for every mask value. In each transfer it tries command and control writes while busy, so that any leak through the lock shows up in the registers.

// File: rtl/msgobj_xfer.sv
module msgobj_xfer #(
  parameter int NUM_OBJ     = 32,
  parameter int XFER_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [2:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        busy
);
  localparam int IW = $clog2(NUM_OBJ);
  localparam int CW = $clog2(XFER_CYCLES);
  localparam int OW = 32 + 32 + 12 + 32 + 32;
  localparam logic [2:0] A_CMD = 3'd0, A_REQ = 3'd1, A_MSK = 3'd2, A_ARB = 3'd3,
                         A_CTL = 3'd4, A_DLO = 3'd5, A_DHI = 3'd6;

  logic [7:0]    cmd_q, num_q;
  logic [31:0]   bm, ba, bda, bdb;
  logic [11:0]   bc;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx_q;
  logic [OW-1:0] mem [NUM_OBJ];
  logic [OW-1:0] rd_q, wr_obj;
  logic [11:0]   oc_n;

  wire cpu_ok = cpu_we && !busy;
  wire start  = cpu_ok && (cpu_addr == A_REQ);
  wire [7:0]    nm1   = cpu_wdata[7:0] - 8'd1;
  wire [IW-1:0] idx_d = (cpu_wdata[7:0] == 8'd0) ? '0 : IW'(nm1 % 8'(NUM_OBJ));

  wire dir_w = cmd_q[7];
  wire g_msk = cmd_q[6];
  wire g_arb = cmd_q[5];
  wire g_ctl = cmd_q[4];
  wire g_clr = cmd_q[3];
  wire g_txn = cmd_q[2];
  wire g_dlo = cmd_q[1];
  wire g_dhi = cmd_q[0];

  wire [31:0] om  = rd_q[108 +: 32];
  wire [31:0] oa  = rd_q[76 +: 32];
  wire [11:0] oc  = rd_q[64 +: 12];
  wire [31:0] oda = rd_q[32 +: 32];
  wire [31:0] odb = rd_q[0 +: 32];

  wire fetch = busy && (cnt == '0);
  wire upd   = busy && (cnt == CW'(1));

  always_comb begin
    oc_n = oc;
    if (dir_w) begin
      if (g_ctl) oc_n = bc;
      if (g_txn) oc_n[9] = 1'b1;
    end else begin
      if (g_clr) oc_n[10] = 1'b0;
      if (g_txn) oc_n[11] = 1'b0;
    end
  end

  assign wr_obj = {(dir_w && g_msk) ? bm  : om,
                   (dir_w && g_arb) ? ba  : oa,
                   oc_n,
                   (dir_w && g_dlo) ? bda : oda,
                   (dir_w && g_dhi) ? bdb : odb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      idx_q <= '0;
      cmd_q <= '0;
      num_q <= '0;
      bm    <= '0;
      ba    <= '0;
      bc    <= '0;
      bda   <= '0;
      bdb   <= '0;
    end else begin
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        num_q <= cpu_wdata[7:0];
        idx_q <= idx_d;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(XFER_CYCLES - 1)) busy <= 1'b0;
      end
      if (cpu_ok) begin
        case (cpu_addr)
          A_CMD:   cmd_q <= cpu_wdata[7:0];
          A_MSK:   bm    <= {cpu_wdata[31:30], 1'b0, cpu_wdata[28:0]};
          A_ARB:   ba    <= cpu_wdata;
          A_CTL:   bc    <= cpu_wdata[11:0];
          A_DLO:   bda   <= cpu_wdata;
          A_DHI:   bdb   <= cpu_wdata;
          default: ;
        endcase
      end
      if (upd && !dir_w) begin
        if (g_msk) bm  <= om;
        if (g_arb) ba  <= oa;
        if (g_ctl) bc  <= oc;
        if (g_dlo) bda <= oda;
        if (g_dhi) bdb <= odb;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fetch) rd_q <= mem[idx_q];
    if (upd)   mem[idx_q] <= wr_obj;
  end

  always_comb begin
    case (cpu_addr)
      A_CMD:   cpu_rdata = {24'd0, cmd_q};
      A_REQ:   cpu_rdata = {16'd0, busy, 7'd0, num_q};
      A_MSK:   cpu_rdata = bm;
      A_ARB:   cpu_rdata = ba;
      A_CTL:   cpu_rdata = {20'd0, bc};
      A_DLO:   cpu_rdata = bda;
      A_DHI:   cpu_rdata = bdb;
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msgobj_xfer_chk.sv
module msgobj_xfer_chk #(
  parameter int XFER_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_we,
  input logic [2:0]  cpu_addr,
  input logic        busy,
  input logic [7:0]  cmd_q,
  input logic [11:0] buf_ctl,
  input logic [31:0] buf_dlo
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !busy && cpu_addr == 3'd1) |=> busy);

  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run != 0) |-> (run == XFER_CYCLES));

  assert_cmd_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && cpu_addr == 3'd0) |=> $stable(cmd_q));

  assert_buffer_kept_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q[7]) |=> ($stable(buf_ctl) && $stable(buf_dlo)));
endmodule

bind msgobj_xfer msgobj_xfer_chk #(.XFER_CYCLES(XFER_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .busy(busy),
  .cmd_q(cmd_q), .buf_ctl(bc), .buf_dlo(bda)
);

// File: tb/test_msgobj_xfer.sv
module test_msgobj_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [2:0]  cpu_addr = 3'd0;
  logic [31:0] cpu_wdata = 32'd0;
  logic [31:0] cpu_rdata;
  logic        busy;

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] om [32];
  logic [31:0] oa [32];
  logic [11:0] oc [32];
  logic [31:0] oda [32];
  logic [31:0] odb [32];
  logic [31:0] bm, ba, bda, bdb;
  logic [11:0] bc;

  always #4 clk = ~clk;

  msgobj_xfer i_msgobj_xfer (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  function automatic int obj_of(input logic [7:0] n);
    return (n == 8'd0) ? 0 : (int'(n) - 1) % 32;
  endfunction

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'h9E3779B9 * (i * 7 + k + 1)) ^ (i << 3);
  endfunction

  task automatic model(input logic [7:0] c, input logic [7:0] n);
    int x;
    logic [11:0] pre;
    x = obj_of(n);
    pre = oc[x];
    if (c[7]) begin
      if (c[6]) om[x] = bm;
      if (c[5]) oa[x] = ba;
      if (c[4]) oc[x] = bc;
      if (c[2]) oc[x][9] = 1'b1;
      if (c[1]) oda[x] = bda;
      if (c[0]) odb[x] = bdb;
    end else begin
      if (c[6]) bm = om[x];
      if (c[5]) ba = oa[x];
      if (c[4]) bc = pre;
      if (c[3]) oc[x][10] = 1'b0;
      if (c[2]) oc[x][11] = 1'b0;
      if (c[1]) bda = oda[x];
      if (c[0]) bdb = odb[x];
    end
  endtask

  task automatic load_buf(input int i);
    wr(3'd2, pat(i, 0)); bm  = pat(i, 0) & 32'hDFFF_FFFF;
    wr(3'd3, pat(i, 1)); ba  = pat(i, 1);
    wr(3'd4, pat(i, 2)); bc  = pat(i, 2)[11:0];
    wr(3'd5, pat(i, 3)); bda = pat(i, 3);
    wr(3'd6, pat(i, 4)); bdb = pat(i, 4);
  endtask

  task automatic run_xfer(input logic [7:0] c, input logic [7:0] n);
    int nb;
    logic [31:0] d;
    wr(3'd0, {24'd0, c});
    wr(3'd1, {24'd0, n});
    rd(3'd1, d);
    chk({31'd0, d[15]}, 32'd1, "R1 busy after start");
    nb = 0;
    while (busy && nb < 20) begin
      nb++;
      cpu_we    = (nb == 2 || nb == 3);
      cpu_addr  = (nb == 2) ? 3'd0 : 3'd4;
      cpu_wdata = (nb == 2) ? {24'd0, ~c} : ~{20'd0, bc};
      @(negedge clk);
    end
    cpu_we = 1'b0;
    chk(nb, 4, "R2 busy length");
    model(c, n);
    rd(3'd0, d);
    chk(d, {24'd0, c}, "R3 command kept");
    rd(3'd1, d);
    chk(d, {24'd0, n}, "R3 number kept, R1 readback");
  endtask

  task automatic check_buf(input string s_ma, input string s_c, input string s_d);
    logic [31:0] d;
    rd(3'd2, d); chk(d, bm, s_ma);
    rd(3'd3, d); chk(d, ba, s_ma);
    rd(3'd4, d); chk(d, {20'd0, bc}, s_c);
    rd(3'd5, d); chk(d, bda, s_d);
    rd(3'd6, d); chk(d, bdb, s_d);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], d);
      chk(d, 32'd0, "R1 reset state");
    end
    chk({31'd0, busy}, 32'd0, "R2 idle after reset");

    for (int k = 1; k <= 32; k++) begin
      load_buf(1000 + k);
      run_xfer(8'hF3, k[7:0]);
    end

    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      logic [7:0] n;
      c = i[7:0];
      n = 8'(i % 40);
      load_buf(i);
      run_xfer(c, n);
      if (c[7]) check_buf("R8 buffer unchanged", "R9 R10 buffer unchanged", "R7 R8 buffer data");
      else      check_buf("R5 group read", "R6 control pre-clear", "R7 data halves read");
      run_xfer(8'h73, n);
      check_buf("R4 R8 object groups", "R4 R6 R9 R10 object control", "R4 R7 object data");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule